// File: doc/BRIEF.md
# Completion Receive-Space Reservation Guard

An endpoint that sends memory read requests advertises infinite completion credit, yet the buffer that holds the returning completions is finite. This block keeps that buffer from overflowing. It holds two fixed capacities: one counts completion header slots and the other counts 16-byte data units. Before a read request leaves, the block works out how many header slots and data units its completions can take, and it grants the request only when both fit next to what is already outstanding.

A granted request reserves its share in the same cycle. As the receive side drains completions, it returns header and data-unit counts on a release port, and the reservation shrinks by those counts. If a release asks to return more than is outstanding, the count is clamped to zero and a sticky error flag is raised. Building the request itself, reassembling completions and managing tags belong to other blocks.

Top module: `cpl_space_guard`

## Requirements
- R1: After synchronous active-low reset, both outstanding counts are zero and the error flag is low.
- R2: A request of L bytes needs ceil(L/16) data units.
- R3: A request of L bytes needs ceil(L/RCB) header slots, where RCB is 64 bytes by default.
- R4: The grant needs outstanding headers plus needed headers to be at most the header capacity, so an exact fit is granted.
- R5: The grant needs outstanding units plus needed units to be strictly less than the data capacity, so an exact fit is refused.
- R6: The counts grow only when the request is valid and granted; a refused request leaves both counts unchanged.
- R7: A valid release subtracts its header count and its unit count from the outstanding counts on the next clock edge.
- R8: A granted request and a release in the same cycle are both applied.
- R9: A release larger than the outstanding count plus any reservation in the same cycle clamps that count to zero, leaves the other count to update normally, and sets the error flag.
- R10: The grant depends on the counts held at the start of the cycle; a release in the same cycle does not widen it.
- R11: The error flag stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_hdr | input | 8 | Header slots held by the receive buffer (static) |
| cap_units | input | 12 | 16-byte data units held by the receive buffer (static) |
| req_valid | input | 1 | A read request is presented |
| req_len | input | 13 | Request length in bytes |
| req_grant | output | 1 | The presented request fits and may be issued |
| rel_valid | input | 1 | Completion space is being returned |
| rel_hdr | input | 8 | Header slots returned |
| rel_units | input | 12 | Data units returned |
| out_hdr | output | 8 | Outstanding header slots |
| out_units | output | 12 | Outstanding data units |
| err_underflow | output | 1 | Sticky flag: a release exceeded the outstanding count |

## Verification
The bench builds the block with its default parameters: 8-bit header and 12-bit unit counters, 13-bit lengths, a 64-byte completion boundary and 16-byte units. It resets between scenarios with different capacities. A header capacity of 4 with 40 units lets the header limit bind first and shows the inclusive exact fit. A header capacity of 200 with 10 units lets the data limit bind and shows the exclusive exact-fit refusal. With these small capacities every boundary is reached within a few requests whose lengths sit just either side of the 16-byte and 64-byte rounding steps.

// File: rtl/cpl_space_pkg.sv
// Shared constants and types for the completion receive-space guard.
// Assumes: capacities are static while out of reset.
package cpl_space_pkg;
    localparam int CPL_HDR_W  = 8;
    localparam int CPL_UNIT_W = 12;
    localparam int CPL_LEN_W  = 13;

    // How a counter compares its would-be occupancy against its capacity.
    typedef enum logic {
        LIMIT_INCLUSIVE = 1'b0,  // occupancy may equal capacity
        LIMIT_EXCLUSIVE = 1'b1   // occupancy must stay below capacity
    } limit_mode_e;
endpackage

// File: rtl/cpl_need_calc.sv
// Converts a read length in bytes into the header slots and data units its
// completions may occupy. Header slots = ceil(len/RCB), units = ceil(len/UNIT).
// Assumes: RCB_BYTES and UNIT_BYTES are powers of two and the results fit
// in the output widths for every length that is presented.
module cpl_need_calc #(
    parameter int LEN_W      = 13,
    parameter int HDR_W      = 8,
    parameter int UNIT_W     = 12,
    parameter int RCB_BYTES  = 64,
    parameter int UNIT_BYTES = 16
) (
    input  logic [LEN_W-1:0]  len,
    output logic [HDR_W-1:0]  need_hdr,
    output logic [UNIT_W-1:0] need_units
);
    localparam int RCB_SH  = $clog2(RCB_BYTES);
    localparam int UNIT_SH = $clog2(UNIT_BYTES);
    localparam int EXT_W   = LEN_W + 1;

    logic [EXT_W-1:0] len_ext;
    logic [EXT_W-1:0] hdr_round;
    logic [EXT_W-1:0] unit_round;

    // Round up by adding (step - 1) and shifting down by the step.
    always_comb begin
        len_ext    = {1'b0, len};
        hdr_round  = (len_ext + EXT_W'(RCB_BYTES - 1)) >> RCB_SH;
        unit_round = (len_ext + EXT_W'(UNIT_BYTES - 1)) >> UNIT_SH;
        need_hdr   = HDR_W'(hdr_round);
        need_units = UNIT_W'(unit_round);
    end
endmodule

// File: rtl/cpl_occ_counter.sv
// One occupancy counter with its fit test. Adds the needed amount on take,
// subtracts the returned amount on give, both in the same cycle if asked.
// A give larger than the count plus take clamps to zero and pulses underflow.
// MODE picks an inclusive or exclusive comparison against the capacity.
// Assumes: cap is static while out of reset.
module cpl_occ_counter
    import cpl_space_pkg::*;
#(
    parameter int          W    = 8,
    parameter limit_mode_e MODE = LIMIT_INCLUSIVE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cap,
    input  logic [W-1:0] need,
    input  logic         take,
    input  logic         give,
    input  logic [W-1:0] give_amt,
    output logic [W-1:0] count,
    output logic         fits,
    output logic         underflow
);
    logic [W:0]   sum_need;
    logic [W:0]   take_sum;
    logic [W:0]   give_ext;
    logic [W-1:0] count_nxt;

    // Would-be occupancy if the presented need were taken now.
    assign sum_need = {1'b0, count} + {1'b0, need};

    generate
        if (MODE == LIMIT_EXCLUSIVE) begin : g_excl
            assign fits = sum_need < {1'b0, cap};
        end else begin : g_incl
            assign fits = sum_need <= {1'b0, cap};
        end
    endgenerate

    // Next count: reserve then release, clamping at zero on underflow.
    always_comb begin
        take_sum  = {1'b0, count} + (take ? {1'b0, need} : {(W+1){1'b0}});
        give_ext  = give ? {1'b0, give_amt} : {(W+1){1'b0}};
        underflow = give_ext > take_sum;
        count_nxt = underflow ? {W{1'b0}} : W'(take_sum - give_ext);
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count_nxt;
    end

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !give) |=> $stable(count));

    // R9
    clamp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> (count == '0));
endmodule

// File: rtl/cpl_space_guard.sv
// Top: reserves completion receive space for each read request and releases
// it as completions drain. Header slots use an inclusive limit, data units an
// exclusive one. The grant is combinational from the current counts and the
// presented length; a request is taken when req_valid and req_grant are high.
// Assumes: cap_hdr and cap_units change only while in reset.
module cpl_space_guard
    import cpl_space_pkg::*;
#(
    parameter int HDR_W      = CPL_HDR_W,
    parameter int UNIT_W     = CPL_UNIT_W,
    parameter int LEN_W      = CPL_LEN_W,
    parameter int RCB_BYTES  = 64,
    parameter int UNIT_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HDR_W-1:0]  cap_hdr,
    input  logic [UNIT_W-1:0] cap_units,
    input  logic              req_valid,
    input  logic [LEN_W-1:0]  req_len,
    output logic              req_grant,
    input  logic              rel_valid,
    input  logic [HDR_W-1:0]  rel_hdr,
    input  logic [UNIT_W-1:0] rel_units,
    output logic [HDR_W-1:0]  out_hdr,
    output logic [UNIT_W-1:0] out_units,
    output logic              err_underflow
);
    logic [HDR_W-1:0]  need_hdr;
    logic [UNIT_W-1:0] need_units;
    logic              hdr_fits, unit_fits;
    logic              hdr_uf, unit_uf;
    logic              fire;

    cpl_need_calc #(
        .LEN_W(LEN_W), .HDR_W(HDR_W), .UNIT_W(UNIT_W),
        .RCB_BYTES(RCB_BYTES), .UNIT_BYTES(UNIT_BYTES)
    ) u_need (
        .len(req_len), .need_hdr(need_hdr), .need_units(need_units)
    );

    cpl_occ_counter #(.W(HDR_W), .MODE(LIMIT_INCLUSIVE)) u_hdr (
        .clk(clk), .rst_n(rst_n), .cap(cap_hdr), .need(need_hdr),
        .take(fire), .give(rel_valid), .give_amt(rel_hdr),
        .count(out_hdr), .fits(hdr_fits), .underflow(hdr_uf)
    );

    cpl_occ_counter #(.W(UNIT_W), .MODE(LIMIT_EXCLUSIVE)) u_unit (
        .clk(clk), .rst_n(rst_n), .cap(cap_units), .need(need_units),
        .take(fire), .give(rel_valid), .give_amt(rel_units),
        .count(out_units), .fits(unit_fits), .underflow(unit_uf)
    );

    // Grant only when both resources fit; take on valid and grant.
    assign req_grant = hdr_fits && unit_fits;
    assign fire      = req_valid && req_grant;

    // Sticky underflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                err_underflow <= 1'b0;
        else if (hdr_uf || unit_uf) err_underflow <= 1'b1;
    end

    // R4
    hdr_within_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_hdr <= cap_hdr);

    // R5
    unit_below_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_units == '0) ? (out_units == '0) : (out_units < cap_units));

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_underflow |=> err_underflow);

    // R9
    err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_uf || unit_uf) |=> err_underflow);
endmodule

// File: tb/sim_cpl_space_guard.sv
`timescale 1ns/1ps
module sim_cpl_space_guard;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  cap_hdr;
    logic [11:0] cap_units;
    logic        req_valid;
    logic [12:0] req_len;
    logic        req_grant;
    logic        rel_valid;
    logic [7:0]  rel_hdr;
    logic [11:0] rel_units;
    logic [7:0]  out_hdr;
    logic [11:0] out_units;
    logic        err_underflow;

    int checks = 0;
    int errors = 0;
    int exp_h  = 0;
    int exp_u  = 0;
    bit exp_err = 0;

    always #2.5 clk = ~clk;

    cpl_space_guard u0 (
        .clk(clk), .rst_n(rst_n), .cap_hdr(cap_hdr), .cap_units(cap_units),
        .req_valid(req_valid), .req_len(req_len), .req_grant(req_grant),
        .rel_valid(rel_valid), .rel_hdr(rel_hdr), .rel_units(rel_units),
        .out_hdr(out_hdr), .out_units(out_units), .err_underflow(err_underflow)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_state(input string tag);
        check({tag, " hdr"}, out_hdr, exp_h);
        check({tag, " units"}, out_units, exp_u);
        check({tag, " err"}, err_underflow, exp_err);
    endtask

    // Reset with new capacities; checks R1.
    task automatic do_reset(input int ch, input int cu);
        @(negedge clk);
        rst_n = 1'b0; cap_hdr = 8'(ch); cap_units = 12'(cu);
        req_valid = 1'b0; req_len = '0; rel_valid = 1'b0; rel_hdr = '0; rel_units = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        exp_h = 0; exp_u = 0; exp_err = 0;
        @(negedge clk);
        check_state("R1 reset");
    endtask

    // Optional request plus optional release in one cycle.
    task automatic cycle_op(input string tag, input bit rq, input int len, input bit exp_g,
                            input bit rl, input int rh, input int ru);
        int nh, nu, sh, su;
        req_valid = rq; req_len = 13'(len);
        rel_valid = rl; rel_hdr = 8'(rh); rel_units = 12'(ru);
        #1;
        if (rq) check({tag, " grant"}, req_grant, exp_g);
        nh = (len + 63) / 64;
        nu = (len + 15) / 16;
        sh = exp_h + ((rq && exp_g) ? nh : 0);
        su = exp_u + ((rq && exp_g) ? nu : 0);
        if (rl) begin
            if (rh > sh) begin sh = 0; exp_err = 1; end else sh = sh - rh;
            if (ru > su) begin su = 0; exp_err = 1; end else su = su - ru;
        end
        exp_h = sh; exp_u = su;
        @(negedge clk);
        req_valid = 1'b0; rel_valid = 1'b0;
        check_state(tag);
    endtask

    // R2 R3 R4 R6: rounding and inclusive header limit, cap 4 hdr / 40 units.
    task automatic t_header_limit();
        do_reset(4, 40);
        cycle_op("R2 R3 len1",  1, 1,  1, 0, 0, 0);   // (1,1)
        cycle_op("R2 R3 len17", 1, 17, 1, 0, 0, 0);   // (2,3)
        cycle_op("R2 len16",    1, 16, 1, 0, 0, 0);   // (3,4)
        cycle_op("R4 exact fit len64", 1, 64, 1, 0, 0, 0); // (4,8)
        cycle_op("R4 R6 refused",      1, 1,  0, 0, 0, 0); // unchanged
        cycle_op("R7 release", 0, 0, 0, 1, 2, 5);     // (2,3)
        cycle_op("R3 len65 two hdr", 1, 65, 1, 0, 0, 0); // (4,8)
        cycle_op("R7 release all", 0, 0, 0, 1, 4, 8);
    endtask

    // R5 R6: exclusive unit limit, cap 200 hdr / 10 units.
    task automatic t_unit_limit();
        do_reset(200, 10);
        cycle_op("R5 exact fit len160 refused", 1, 160, 0, 0, 0, 0);
        cycle_op("R5 len144 fits", 1, 144, 1, 0, 0, 0);   // (3,9)
        cycle_op("R5 R6 one more refused", 1, 16, 0, 0, 0, 0);
    endtask

    // R8 R10: simultaneous request and release.
    task automatic t_simultaneous();
        cycle_op("R10 release no widen", 1, 16, 0, 1, 1, 4); // (2,5)
        cycle_op("R8 both applied", 1, 32, 1, 1, 1, 1);     // (2,6)
    endtask

    // R9 R11: underflow clamp and sticky error.
    task automatic t_underflow();
        cycle_op("R9 hdr underflow", 0, 0, 0, 1, 5, 0);     // (0,6) err
        cycle_op("R11 sticky", 0, 0, 0, 1, 0, 6);           // (0,0) err
        do_reset(4, 40);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cap_hdr = '0; cap_units = '0;
        req_valid = 1'b0; req_len = '0; rel_valid = 1'b0; rel_hdr = '0; rel_units = '0;
        t_header_limit();
        t_unit_limit();
        t_simultaneous();
        t_underflow();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule